// File: doc/BRIEF.md
# Mixed-Page-Size Translation Lookaside Buffer

This block caches recent virtual-to-physical translations in front of a page table walker. A requester presents a 48-bit virtual address on the lookup port. One cycle later the block answers with a hit flag, a 44-bit physical address and the permission bits of the matching entry. On a miss the block raises a walk request that carries the missing virtual page number. It holds that request, and refuses further lookups, until the walker returns a frame, a page-size code and permissions. These are then installed as a new entry, and the requester retries.

Each entry records its own page size: 4 KB, 2 MB or 1 GB. Tag comparison and physical-address assembly therefore use a per-entry mask, and all three sizes can live side by side in the same fully associative array. Software keeps the cache coherent with page-table edits through two operations:
- a single-address invalidate, which removes every entry that the given address would hit;
- a full flush, which empties the array in one cycle.

The control is a two-state machine. `ST_READY` accepts lookups. The `LOOKUP_MISS` transition leads to `ST_WALK`, which holds the walk request. The `FILL_DONE` transition, taken when the walker response arrives, returns to `ST_READY`. Replacement prefers an entry that overlaps the incoming page, then the lowest free slot, then a round-robin pointer.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, `lk_ready` is 1, and `walk_req` and `rsp_valid` are 0.
- R2: A lookup is accepted in the cycle where `lk_valid` and `lk_ready` are both 1. On the next cycle `rsp_valid` is 1. On a hit, `rsp_hit` is 1 and `rsp_pa` and `rsp_perm` come from the matching entry. In every cycle without an accepted lookup, `rsp_valid` is 0 on the following cycle.
- R3: On a miss, the response carries `rsp_hit`=0 and `rsp_pa`=0. From that same cycle `walk_req` is 1 and `walk_vpn` equals the virtual address bits 47..12. `lk_ready` stays 0 while the walk is outstanding.
- R4: A `fill_valid` pulse during a walk installs the entry and returns the block to ready: `walk_req` is 0 and `lk_ready` is 1 on the next cycle. A later lookup of the same page hits.
- R5: The `fill_size` codes and their effect on matching and on the physical address are:

  | Code | Page size | Virtual bits compared | Physical bits taken from the virtual address |
  |------|-----------|-----------------------|----------------------------------------------|
  | 0 | 4 KB | 47..12 | 11..0 |
  | 1 | 2 MB | 47..21 | 20..0 |
  | 2 | 1 GB | 47..30 | 29..0 |
  | 3 | treated as 4 KB | 47..12 | 11..0 |

  For codes 1 and 2, the physical frame bits below the page boundary are ignored.
- R6: A fill with no overlapping entry goes to the lowest-numbered invalid slot. When every slot is valid, it goes to the slot named by a round-robin pointer. The pointer starts at 0 and advances by one only on such an eviction.
- R7: On a fill, every valid entry whose page overlaps the new page is removed. Overlap is tested with the mask of the larger of the two page sizes. The new entry takes the lowest overlapping slot, so no address ever hits two entries.
- R8: An invalidate (`inv_valid`) removes every entry that a lookup of `inv_va` would hit, and leaves all other entries usable.
- R9: `flush_all` invalidates all entries in one cycle. A fill arriving in the same cycle as a flush is discarded, although the walk still ends.
- R10: In a cycle where `inv_valid` or `flush_all` is high, `lk_ready` is 0 and no lookup is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 48 | Lookup virtual address |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_hit | output | 1 | Translation found |
| rsp_pa | output | 44 | Translated physical address (0 on miss) |
| rsp_perm | output | PERM_W | Permission bits of the hit entry (0 on miss) |
| walk_req | output | 1 | Walk outstanding |
| walk_vpn | output | 36 | Virtual page number (address bits 47..12) to walk |
| fill_valid | input | 1 | Walker response valid |
| fill_pfn | input | 32 | Physical frame number (address bits 43..12) |
| fill_size | input | 2 | Page-size code of the fill |
| fill_perm | input | PERM_W | Permission bits of the fill |
| inv_valid | input | 1 | Invalidate the entries matching inv_va |
| inv_va | input | 48 | Address to invalidate |
| flush_all | input | 1 | Invalidate all entries |

## Verification
Lookups are driven with:
- offsets at both ends of a 4 KB page and with addresses on adjacent pages, which separates the 4 KB tag width from any wider one;
- addresses spread across a 2 MB and a 1 GB region, which shows that the low virtual bits pass through and the low frame bits are dropped;
- an address just past a 2 MB region and a fill with size code 3, which expose a mask that is too wide.

Filling all 64 slots and then forcing misses checks the eviction order. An invalidated hole placed in the middle shows that a free slot wins over the round-robin pointer. A 2 MB fill over two resident 4 KB pages checks that overlapping entries merge into one. Invalidates, flushes and a flush that coincides with a fill check that no stale translation survives.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W  = 48;
    localparam int PA_W  = 44;
    localparam int OFS_W = 12;
    localparam int LVL_W = 9;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PFN_W = PA_W - OFS_W;

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_2M  = 2'd1,
        SZ_1G  = 2'd2,
        SZ_RSV = 2'd3
    } pg_sz_e;

    // Reserved code behaves like the base page size.
    function automatic logic [1:0] sz_norm(input logic [1:0] sz);
        return (sz == SZ_RSV) ? SZ_4K : sz;
    endfunction

    // Ones on the page-number bits that take part in the compare.
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] m;
        m = '1;
        case (sz_norm(sz))
            SZ_2M:   m[LVL_W-1:0]   = '0;
            SZ_1G:   m[2*LVL_W-1:0] = '0;
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic logic [1:0] sz_coarse(input logic [1:0] a, input logic [1:0] b);
        logic [1:0] na;
        logic [1:0] nb;
        na = sz_norm(a);
        nb = sz_norm(b);
        return (na > nb) ? na : nb;
    endfunction
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int N      = 64,
    parameter int PERM_W = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  look_vpn,
    output logic [N-1:0]      hit_vec,
    output logic [PFN_W-1:0]  hit_pfn,
    output logic [1:0]        hit_sz,
    output logic [PERM_W-1:0] hit_perm,
    input  logic [VPN_W-1:0]  new_vpn,
    input  logic [1:0]        new_sz,
    output logic [N-1:0]      ovl_vec,
    output logic [N-1:0]      vld_vec,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              kill_en,
    input  logic [VPN_W-1:0]  kill_vpn,
    input  logic              flush
);
    logic [VPN_W-1:0]  ent_vpn  [N];
    logic [PFN_W-1:0]  ent_pfn  [N];
    logic [1:0]        ent_sz   [N];
    logic [PERM_W-1:0] ent_perm [N];
    logic [N-1:0]      vld;
    logic [N-1:0]      kill_vec;

    assign vld_vec = vld;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [VPN_W-1:0] own_m;
        logic [VPN_W-1:0] ovl_m;
        logic             sel;

        assign own_m       = vpn_mask(ent_sz[g]);
        assign ovl_m       = vpn_mask(sz_coarse(ent_sz[g], new_sz));
        assign sel         = wr_en && (wr_idx == IDX_W'(g));
        assign hit_vec[g]  = vld[g] && (((ent_vpn[g] ^ look_vpn) & own_m) == '0);
        assign ovl_vec[g]  = vld[g] && (((ent_vpn[g] ^ new_vpn) & ovl_m) == '0);
        assign kill_vec[g] = kill_en && vld[g] && (((ent_vpn[g] ^ kill_vpn) & own_m) == '0);

        always_ff @(posedge clk) begin
            if (!rst_n)                         vld[g] <= 1'b0;
            else if (flush)                     vld[g] <= 1'b0;
            else if (sel)                       vld[g] <= 1'b1;
            else if (kill_vec[g] || (wr_en && ovl_vec[g])) vld[g] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (sel && !flush) begin
                ent_vpn[g]  <= new_vpn;
                ent_pfn[g]  <= wr_pfn;
                ent_sz[g]   <= new_sz;
                ent_perm[g] <= wr_perm;
            end
        end
    end

    always_comb begin
        hit_pfn  = '0;
        hit_sz   = '0;
        hit_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_pfn  |= ent_pfn[i];
                hit_sz   |= ent_sz[i];
                hit_perm |= ent_perm[i];
            end
        end
    end

    // R7
    multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld == '0));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N      = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     vld_vec,
    input  logic [N-1:0]     ovl_vec,
    input  logic             take,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] rr;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] ovl_idx;
    logic             free_any;
    logic             ovl_any;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        ovl_any  = 1'b0;
        ovl_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld_vec[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
            if (ovl_vec[i]) begin
                ovl_any = 1'b1;
                ovl_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (ovl_any)       idx = ovl_idx;
        else if (free_any) idx = free_idx;
        else               idx = rr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rr <= '0;
        else if (take && !ovl_any && !free_any)
            rr <= (rr == IDX_W'(N - 1)) ? '0 : rr + 1'b1;
    end

    // R6
    free_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !(|ovl_vec) && !(&vld_vec)) |-> !vld_vec[idx]);

    // R7
    ovl_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (|ovl_vec)) |-> ovl_vec[idx]);
endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lk_valid,
    input  logic lk_hit,
    input  logic fill_valid,
    input  logic flush,
    input  logic kill,
    output logic lk_ready,
    output logic accept,
    output logic walking,
    output logic install
);
    typedef enum logic {ST_READY, ST_WALK} st_e;

    st_e state;
    st_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_READY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_READY: if (accept && !lk_hit) nxt = ST_WALK;   // LOOKUP_MISS
            ST_WALK:  if (fill_valid)        nxt = ST_READY;  // FILL_DONE
        endcase
    end

    always_comb begin
        lk_ready = 1'b0;
        walking  = 1'b0;
        install  = 1'b0;
        unique case (state)
            ST_READY: lk_ready = !flush && !kill;
            ST_WALK: begin
                walking = 1'b1;
                install = fill_valid && !flush;
            end
        endcase
        accept = lk_valid && lk_ready;
    end

    // R3
    miss_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !lk_hit) |=> walking);

    // R4
    fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (walking && fill_valid) |=> (!walking && $fell(walking)));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int N_ENT  = 64,
    parameter int PERM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    output logic              lk_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              walk_req,
    output logic [VPN_W-1:0]  walk_vpn,
    input  logic              fill_valid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_size,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              inv_valid,
    input  logic [VA_W-1:0]   inv_va,
    input  logic              flush_all
);
    localparam int IDX_W = $clog2(N_ENT);

    logic [VPN_W-1:0]  look_vpn;
    logic [N_ENT-1:0]  hit_vec;
    logic [N_ENT-1:0]  ovl_vec;
    logic [N_ENT-1:0]  vld_vec;
    logic [PFN_W-1:0]  hit_pfn;
    logic [1:0]        hit_sz;
    logic [PERM_W-1:0] hit_perm;
    logic [VPN_W-1:0]  hit_m;
    logic [PFN_W-1:0]  pa_frame;
    logic [IDX_W-1:0]  vic_idx;
    logic              lk_hit;
    logic              accept;
    logic              install;
    logic [VPN_W-1:0]  miss_vpn;

    assign look_vpn = lk_va[VA_W-1:OFS_W];
    assign lk_hit   = |hit_vec;
    assign walk_vpn = miss_vpn;

    xlat_cam #(.N(N_ENT), .PERM_W(PERM_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_vpn (look_vpn),
        .hit_vec  (hit_vec),
        .hit_pfn  (hit_pfn),
        .hit_sz   (hit_sz),
        .hit_perm (hit_perm),
        .new_vpn  (miss_vpn),
        .new_sz   (fill_size),
        .ovl_vec  (ovl_vec),
        .vld_vec  (vld_vec),
        .wr_en    (install),
        .wr_idx   (vic_idx),
        .wr_pfn   (fill_pfn),
        .wr_perm  (fill_perm),
        .kill_en  (inv_valid),
        .kill_vpn (inv_va[VA_W-1:OFS_W]),
        .flush    (flush_all)
    );

    xlat_victim #(.N(N_ENT)) u_vic (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_vec (vld_vec),
        .ovl_vec (ovl_vec),
        .take    (install),
        .idx     (vic_idx)
    );

    xlat_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_hit     (lk_hit),
        .fill_valid (fill_valid),
        .flush      (flush_all),
        .kill       (inv_valid),
        .lk_ready   (lk_ready),
        .accept     (accept),
        .walking    (walk_req),
        .install    (install)
    );

    // Frame bits above the page boundary come from the entry, the rest from the VA.
    assign hit_m    = vpn_mask(hit_sz);
    assign pa_frame = (hit_pfn & hit_m[PFN_W-1:0]) | (look_vpn[PFN_W-1:0] & ~hit_m[PFN_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_vpn <= '0;
        end else if (accept && !lk_hit) begin
            miss_vpn <= look_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pa    <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                rsp_hit  <= lk_hit;
                rsp_pa   <= lk_hit ? {pa_frame, lk_va[OFS_W-1:0]} : '0;
                rsp_perm <= lk_hit ? hit_perm : '0;
            end
        end
    end

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rsp_valid);

    // R2
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !rsp_valid);

    // R10
    maint_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid || flush_all) |-> !lk_ready);
endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [47:0] lk_va = '0;
    logic        lk_ready;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [43:0] rsp_pa;
    logic [3:0]  rsp_perm;
    logic        walk_req;
    logic [35:0] walk_vpn;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_pfn = '0;
    logic [1:0]  fill_size = '0;
    logic [3:0]  fill_perm = '0;
    logic        inv_valid = 1'b0;
    logic [47:0] inv_va = '0;
    logic        flush_all = 1'b0;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    xlat_cache #(.N_ENT(64), .PERM_W(4)) dut_i (.*);

    typedef struct packed {
        logic [47:0] va;
        logic        exp_hit;
        logic [43:0] exp_pa;
        logic [3:0]  exp_perm;
        logic [31:0] f_pfn;
        logic [1:0]  f_sz;
        logic [3:0]  f_perm;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{48'h0000_1234_5678, 1'b0, 44'h0,           4'h0, 32'h0000_00AB, 2'd0, 4'h3},
        '{48'h0000_1234_5678, 1'b1, 44'h000_000A_B678, 4'h3, 32'h0, 2'd0, 4'h0},
        '{48'h0000_1234_5FFF, 1'b1, 44'h000_000A_BFFF, 4'h3, 32'h0, 2'd0, 4'h0},
        '{48'h0000_1234_6000, 1'b0, 44'h0,           4'h0, 32'h0000_01CD, 2'd0, 4'h5},
        '{48'h0000_1234_6010, 1'b1, 44'h000_001C_D010, 4'h5, 32'h0, 2'd0, 4'h0},
        '{48'h00AB_C020_1234, 1'b0, 44'h0,           4'h0, 32'h0000_56A5, 2'd1, 4'h6},
        '{48'h00AB_C020_1234, 1'b1, 44'h000_0560_1234, 4'h6, 32'h0, 2'd0, 4'h0},
        '{48'h00AB_C03F_FFFF, 1'b1, 44'h000_057F_FFFF, 4'h6, 32'h0, 2'd0, 4'h0},
        '{48'h7FFF_A1B2_C3D4, 1'b0, 44'h0,           4'h0, 32'h0012_3456, 2'd2, 4'h7},
        '{48'h7FFF_A1B2_C3D4, 1'b1, 44'h001_21B2_C3D4, 4'h7, 32'h0, 2'd0, 4'h0},
        '{48'h7FFF_8000_0000, 1'b1, 44'h001_0000_0000, 4'h7, 32'h0, 2'd0, 4'h0},
        '{48'h0000_0000_3000, 1'b0, 44'h0,           4'h0, 32'h0000_0777, 2'd3, 4'h1},
        '{48'h0000_0000_3ABC, 1'b1, 44'h000_0077_7ABC, 4'h1, 32'h0, 2'd0, 4'h0},
        '{48'h0000_0000_4000, 1'b0, 44'h0,           4'h0, 32'h0000_0888, 2'd0, 4'h9},
        '{48'h0000_0000_4321, 1'b1, 44'h000_0088_8321, 4'h9, 32'h0, 2'd0, 4'h0},
        '{48'h00AB_C040_0000, 1'b0, 44'h0,           4'h0, 32'h0000_2222, 2'd0, 4'h4}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_lookup(input logic [47:0] va);
        lk_valid = 1'b1;
        lk_va    = va;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [31:0] pfn, input logic [1:0] sz, input logic [3:0] perm);
        fill_valid = 1'b1;
        fill_pfn   = pfn;
        fill_size  = sz;
        fill_perm  = perm;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Lookup; on an expected miss, check the walk request and serve the fill.
    task automatic probe(input logic [47:0] va, input bit exp_hit, input logic [43:0] exp_pa,
                         input logic [3:0] exp_perm, input logic [31:0] f_pfn,
                         input logic [1:0] f_sz, input logic [3:0] f_perm, input string req);
        do_lookup(va);
        chk(rsp_valid == 1'b1, {req, " R2 rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_hit == exp_hit, {req, " hit"}, 64'(rsp_hit), 64'(exp_hit));
        if (exp_hit) begin
            chk(rsp_pa == exp_pa, {req, " R5 pa"}, 64'(rsp_pa), 64'(exp_pa));
            chk(rsp_perm == exp_perm, {req, " R2 perm"}, 64'(rsp_perm), 64'(exp_perm));
        end else begin
            chk(rsp_pa == '0, {req, " R3 pa on miss"}, 64'(rsp_pa), 64'd0);
            chk(walk_req && !lk_ready, {req, " R3 walk/stall"}, 64'({walk_req, lk_ready}), 64'b10);
            chk(walk_vpn == va[47:12], {req, " R3 walk_vpn"}, 64'(walk_vpn), 64'(va[47:12]));
            do_fill(f_pfn, f_sz, f_perm);
            chk(!walk_req && lk_ready, {req, " R4 fill done"}, 64'({walk_req, lk_ready}), 64'b01);
        end
    endtask

    task automatic do_inv(input logic [47:0] va);
        lk_valid  = 1'b1;
        lk_va     = 48'h0000_1234_6010;
        inv_valid = 1'b1;
        inv_va    = va;
        #1;
        chk(lk_ready == 1'b0, "R10 ready during invalidate", 64'(lk_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        inv_valid = 1'b0;
        lk_valid  = 1'b0;
        chk(rsp_valid == 1'b0, "R10 no accept during invalidate", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_flush();
        lk_valid  = 1'b1;
        lk_va     = 48'h0000_1234_6010;
        flush_all = 1'b1;
        #1;
        chk(lk_ready == 1'b0, "R10 ready during flush", 64'(lk_ready), 64'd0);
        @(posedge clk);
        @(negedge clk);
        flush_all = 1'b0;
        lk_valid  = 1'b0;
        chk(rsp_valid == 1'b0, "R10 no accept during flush", 64'(rsp_valid), 64'd0);
    endtask

    function automatic logic [47:0] pg(input int k);
        return 48'h0000_1000_0000 + (48'(k) << 12);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(lk_ready && !walk_req && !rsp_valid, "R1 reset outputs",
            64'({lk_ready, walk_req, rsp_valid}), 64'b100);

        // Main table: mixed page sizes
        for (int i = 0; i < NV; i++) begin
            probe(VECS[i].va, VECS[i].exp_hit, VECS[i].exp_pa, VECS[i].exp_perm,
                  VECS[i].f_pfn, VECS[i].f_sz, VECS[i].f_perm, $sformatf("vec%0d", i));
        end

        // R8: invalidate one 4K page, neighbour survives
        do_inv(48'h0000_1234_5000);
        probe(48'h0000_1234_5678, 1'b0, 44'h0, 4'h0, 32'h0000_00AC, 2'd0, 4'h3, "R8 removed");
        probe(48'h0000_1234_6010, 1'b1, 44'h000_001C_D010, 4'h5, 32'h0, 2'd0, 4'h0, "R8 untouched");
        probe(48'h0000_1234_5678, 1'b1, 44'h000_000A_C678, 4'h3, 32'h0, 2'd0, 4'h0, "R8 refilled");

        // R7: 2M fill over two resident 4K pages
        probe(48'h0000_1234_7000, 1'b0, 44'h0, 4'h0, 32'h0000_9000, 2'd1, 4'h2, "R7 fill");
        probe(48'h0000_1234_5678, 1'b1, 44'h000_0914_5678, 4'h2, 32'h0, 2'd0, 4'h0, "R7 merged a");
        probe(48'h0000_1234_6010, 1'b1, 44'h000_0914_6010, 4'h2, 32'h0, 2'd0, 4'h0, "R7 merged b");

        // R8: invalidate inside a 2M page
        do_inv(48'h00AB_C021_0000);
        probe(48'h00AB_C020_1234, 1'b0, 44'h0, 4'h0, 32'h0000_56A5, 2'd1, 4'h6, "R8 2M removed");

        // R9: flush, then flush coinciding with fill
        do_flush();
        probe(48'h7FFF_A1B2_C3D4, 1'b0, 44'h0, 4'h0, 32'h0012_3456, 2'd2, 4'h7, "R9 after flush");
        probe(48'h7FFF_A1B2_C3D4, 1'b1, 44'h001_21B2_C3D4, 4'h7, 32'h0, 2'd0, 4'h0, "R9 refilled");
        do_lookup(48'h0000_5555_5000);
        chk(walk_req == 1'b1, "R9 walk before flush+fill", 64'(walk_req), 64'd1);
        flush_all = 1'b1;
        do_fill(32'h0000_0555, 2'd0, 4'h1);
        flush_all = 1'b0;
        chk(!walk_req, "R9 walk ended by flush+fill", 64'(walk_req), 64'd0);
        probe(48'h0000_5555_5000, 1'b0, 44'h0, 4'h0, 32'h0000_0556, 2'd0, 4'h1, "R9 fill discarded");
        probe(48'h7FFF_A1B2_C3D4, 1'b0, 44'h0, 4'h0, 32'h0012_3456, 2'd2, 4'h7, "R9 flushed 1G");

        // R6: fill all slots, then round-robin and free-slot priority
        do_flush();
        for (int k = 0; k < 64; k++) begin
            probe(pg(k), 1'b0, 44'h0, 4'h0, 32'h100 + 32'(k), 2'd0, 4'h1, "R6 fill");
        end
        probe(pg(64), 1'b0, 44'h0, 4'h0, 32'h140, 2'd0, 4'h1, "R6 evict slot0");
        probe(pg(1), 1'b1, {32'h101, 12'h0}, 4'h1, 32'h0, 2'd0, 4'h0, "R6 page1 kept");
        probe(pg(0), 1'b0, 44'h0, 4'h0, 32'h150, 2'd0, 4'h1, "R6 page0 evicted");
        probe(pg(1), 1'b0, 44'h0, 4'h0, 32'h151, 2'd0, 4'h1, "R6 rr advanced");
        probe(pg(3), 1'b1, {32'h103, 12'h0}, 4'h1, 32'h0, 2'd0, 4'h0, "R6 page3 kept");
        do_inv(pg(10));
        probe(pg(70), 1'b0, 44'h0, 4'h0, 32'h170, 2'd0, 4'h1, "R6 free slot fill");
        probe(pg(3), 1'b1, {32'h103, 12'h0}, 4'h1, 32'h0, 2'd0, 4'h0, "R6 free slot preferred");
        probe(pg(70), 1'b1, {32'h170, 12'h0}, 4'h1, 32'h0, 2'd0, 4'h0, "R6 new page hits");
        probe(pg(10), 1'b0, 44'h0, 4'h0, 32'h110, 2'd0, 4'h1, "R8 page10 invalid");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule